// File: doc/BRIEF.md
# Multiprocessor Nine-Bit Serial Receiver

This block receives asynchronous 11-bit frames. Each frame has a low start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. The serial line is synchronised and sampled on a tick that runs at sixteen times the bit rate. Each bit is decided by a majority vote of three samples taken around the middle of the bit. The bits move through a nine-bit shift register that is filled with ones when a frame starts. The frame is complete when the start bit's zero has moved to the far end of that register. The bit that arrives at that moment is the ninth bit, and a single decision is made at that point.

At that decision the frame is either committed or dropped. A frame is committed when the receive flag is still clear and either address filtering is off or the ninth bit is one. A committed frame updates the data byte, the ninth-bit register and the flag. A dropped frame changes nothing. The address-filter control lets a node on a multidrop line wait for address frames (ninth bit high) and ignore data traffic addressed to other nodes. The stop bit is never checked. One bit time after the decision the receiver goes back to waiting for a falling edge.

The controller has four states. IDLE waits for a falling edge while reception is enabled. START checks the start bit by vote; a high vote is a false start and returns to IDLE, and a low vote goes to DATA. DATA shifts in bits until the end marker is seen, then makes the final decision and goes to TAIL. TAIL waits one bit time and returns to IDLE.

Top module: `mp9_serial_rx`

## Requirements
- R1: After reset, rx_data is 0, rx_bit9 is 0 and rx_flag is 0.
- R2: A frame starts only on a falling edge of the synchronised line seen while rx_enable is 1. A frame sent while rx_enable is 0 leaves all outputs unchanged.
- R3: The tick on which the edge is found is sample 0. Each bit is the majority of samples 7, 8 and 9 of its 16-sample period. Data arrives least significant bit first and is placed with the first data bit at rx_data bit 0. The ninth bit follows the eighth data bit.
- R4: If the start bit votes high, the receiver treats it as a false start, drops it without changing any output, and waits for a new falling edge.
- R5: A frame is committed when rx_flag is 0 at the final shift and either addr_filter_en is 0 or the ninth bit is 1. A committed frame loads the data byte into rx_data and the ninth bit into rx_bit9, and sets rx_flag. rx_data and rx_bit9 change only at such a commit.
- R6: With addr_filter_en at 1, a frame whose ninth bit is 0 is dropped: rx_data and rx_bit9 keep their values and rx_flag stays 0.
- R7: A frame that completes while rx_flag is 1 is dropped, and rx_data and rx_bit9 keep their values.
- R8: rx_flag stays 1 until a one-cycle flag_clear pulse clears it. The hardware never clears it on its own.
- R9: The value of the stop bit has no effect on rx_data, rx_bit9 or rx_flag.
- R10: One bit time after the final shift, whether or not the frame was committed, the receiver is idle again. It can accept a new start bit that immediately follows a one-bit stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Serial receive line, idles high |
| tick16 | input | 1 | One-cycle enable at 16x bit rate |
| addr_filter_en | input | 1 | 1: commit only frames whose ninth bit is 1 |
| rx_enable | input | 1 | 1: new frames may start |
| flag_clear | input | 1 | One-cycle pulse that clears rx_flag |
| rx_data | output | 8 | Last committed data byte |
| rx_bit9 | output | 1 | Last committed ninth bit |
| rx_flag | output | 1 | Receive flag, set on commit |

## Verification
Directed frames cover each case of the commit decision. The flag is tried clear and set, filtering on and off, and the ninth bit 0 and 1, which separates a correct decision from one that ignores a single term. Frames with a low stop bit, frames sent while reception is disabled, a short low glitch before a real frame, and a frame that follows a one-bit stop bit back to back check the end marker, the vote window and the return to idle. A seeded random run then mixes data values, ninth bits, filter settings, flag clears and idle gaps against a bench model of the commit rule.

// File: rtl/mp9_rx_pkg.sv
package mp9_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_TAIL  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/mp9_rx_sampler.sv
module mp9_rx_sampler #(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_pin,
    input  logic                          tick,
    input  logic                          restart,
    output logic                          fall_seen,
    output logic                          vote,
    output logic                          vote_strobe
);
    localparam int CNT_W   = $clog2(OVERSAMPLE);
    localparam int MID     = OVERSAMPLE / 2;
    localparam int FIRST   = MID - 1;
    localparam int LAST    = MID + 1;
    localparam int TOP     = OVERSAMPLE - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_level;
    logic                   prev_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [1:0]             early_q;

    // line synchroniser, resets to idle-high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
        end
    end

    assign rx_level = sync_q[SYNC_STAGES-1];

    // level seen on the previous tick, for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (tick) begin
            prev_q <= rx_level;
        end
    end

    assign fall_seen = tick && prev_q && !rx_level;

    // position within the current bit period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CNT_W'(1);
        end else if (tick) begin
            if (cnt_q == CNT_W'(TOP)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // first two of the three vote samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_q <= 2'b11;
        end else if (tick) begin
            if (cnt_q == CNT_W'(FIRST)) begin
                early_q[0] <= rx_level;
            end
            if (cnt_q == CNT_W'(FIRST + 1)) begin
                early_q[1] <= rx_level;
            end
        end
    end

    assign vote = (early_q[0] & early_q[1]) |
                  (early_q[0] & rx_level)   |
                  (early_q[1] & rx_level);

    assign vote_strobe = tick && (cnt_q == CNT_W'(LAST));

endmodule

// File: rtl/mp9_rx_shifter.sv
module mp9_rx_shifter #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             at_end
);
    logic [WIDTH-1:0] sr_q;

    // ones fill the register; the start zero travels toward bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (preset) begin
            sr_q <= '1;
        end else if (shift_en) begin
            sr_q <= {din, sr_q[WIDTH-1:1]};
        end
    end

    assign q      = sr_q;
    assign at_end = ~sr_q[0];

endmodule

// File: rtl/mp9_rx_commit.sv
module mp9_rx_commit #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 final_shift,
    input  logic                 ninth_in,
    input  logic [DATA_BITS-1:0] frame_in,
    input  logic                 filter_en,
    input  logic                 flag_clear,
    output logic [DATA_BITS-1:0] data_q,
    output logic                 ninth_q,
    output logic                 flag_q
);
    logic accept;

    assign accept = final_shift && !flag_q && (!filter_en || ninth_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ninth_q <= 1'b0;
        end else if (accept) begin
            data_q  <= frame_in;
            ninth_q <= ninth_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (accept) begin
            flag_q <= 1'b1;
        end else if (flag_clear) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mp9_serial_rx.sv
module mp9_serial_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_pin,
    input  logic                 tick16,
    input  logic                 addr_filter_en,
    input  logic                 rx_enable,
    input  logic                 flag_clear,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_bit9,
    output logic                 rx_flag
);
    import mp9_rx_pkg::*;

    localparam int SR_W = DATA_BITS + 1;

    rx_state_t        state_q, state_d;
    logic             fall_seen, vote, vote_strobe;
    logic             restart, preset, shift_en, final_shift;
    logic [SR_W-1:0]  sr;
    logic             at_end;

    mp9_rx_sampler #(
        .OVERSAMPLE (OVERSAMPLE),
        .SYNC_STAGES(SYNC_STAGES)
    ) sampler_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_pin     (rx_pin),
        .tick       (tick16),
        .restart    (restart),
        .fall_seen  (fall_seen),
        .vote       (vote),
        .vote_strobe(vote_strobe)
    );

    mp9_rx_shifter #(
        .WIDTH(SR_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .shift_en(shift_en),
        .din     (vote),
        .q       (sr),
        .at_end  (at_end)
    );

    mp9_rx_commit #(
        .DATA_BITS(DATA_BITS)
    ) commit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .final_shift(final_shift),
        .ninth_in   (vote),
        .frame_in   (sr[SR_W-1:1]),
        .filter_en  (addr_filter_en),
        .flag_clear (flag_clear),
        .data_q     (rx_data),
        .ninth_q    (rx_bit9),
        .flag_q     (rx_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_seen && rx_enable) state_d = ST_START;
            end
            ST_START: begin
                if (vote_strobe) state_d = vote ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (vote_strobe && at_end) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (vote_strobe) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        restart     = 1'b0;
        preset      = 1'b0;
        shift_en    = 1'b0;
        final_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                restart = fall_seen && rx_enable;
                preset  = fall_seen && rx_enable;
            end
            ST_START: begin
                shift_en = vote_strobe && !vote;
            end
            ST_DATA: begin
                shift_en    = vote_strobe && !at_end;
                final_shift = vote_strobe && at_end;
            end
            ST_TAIL: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mp9_serial_rx_chk.sv
module mp9_serial_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rx_enable,
    input logic                      addr_filter_en,
    input logic                      flag_clear,
    input logic [DATA_BITS-1:0]      rx_data,
    input logic                      rx_bit9,
    input logic                      rx_flag,
    input mp9_rx_pkg::rx_state_t     state,
    input logic                      final_shift
);
    import mp9_rx_pkg::*;

    a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_enable) |=> (state == ST_IDLE));

    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> ($past(final_shift) && (!$past(addr_filter_en) || rx_bit9)));

    a_r5_data_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(rx_data) && $stable(rx_bit9)) |-> $rose(rx_flag));

    a_r7_frozen_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |=> ($stable(rx_data) && $stable(rx_bit9)));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clear) |=> rx_flag);

    a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !final_shift) |=> !rx_flag);

    a_r10_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |=> (state == ST_TAIL || state == ST_IDLE));

endmodule

bind mp9_serial_rx mp9_serial_rx_chk #(
    .DATA_BITS(DATA_BITS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enable     (rx_enable),
    .addr_filter_en(addr_filter_en),
    .flag_clear    (flag_clear),
    .rx_data       (rx_data),
    .rx_bit9       (rx_bit9),
    .rx_flag       (rx_flag),
    .state         (state_q),
    .final_shift   (final_shift)
);

// File: tb/mp9_serial_rx_tb.sv
module mp9_serial_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tick16 = 1'b0;
    logic       addr_filter_en = 1'b0;
    logic       rx_enable = 1'b1;
    logic       flag_clear = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;

    logic [7:0] m_data = 8'h00;
    logic       m_bit9 = 1'b0;
    logic       m_flag = 1'b0;

    mp9_serial_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_pin        (rx_pin),
        .tick16        (tick16),
        .addr_filter_en(addr_filter_en),
        .rx_enable     (rx_enable),
        .flag_clear    (flag_clear),
        .rx_data       (rx_data),
        .rx_bit9       (rx_bit9),
        .rx_flag       (rx_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick16   <= (tick_cnt == TICK_DIV - 1);
    end

    function automatic logic f_accept(logic flag, logic filt, logic b9);
        return !flag && (!filt || b9);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic hold_bits(int n);
        for (int i = 0; i < n * BIT_CLKS; i++) @(negedge clk);
    endtask

    // serial frame: start, 8 data LSB first, ninth bit, stop, idle gap
    task automatic send_frame(logic [7:0] d, logic b9, logic stop, int idle_bits);
        rx_pin = 1'b0;
        hold_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx_pin = d[i];
            hold_bits(1);
        end
        rx_pin = b9;
        hold_bits(1);
        rx_pin = stop;
        hold_bits(1);
        rx_pin = 1'b1;
        hold_bits(idle_bits);
    endtask

    // send a frame and update the model from the commit rule
    task automatic frame_and_model(logic [7:0] d, logic b9, logic stop, int idle_bits);
        if (rx_enable && f_accept(m_flag, addr_filter_en, b9)) begin
            m_data = d;
            m_bit9 = b9;
            m_flag = 1'b1;
        end
        send_frame(d, b9, stop, idle_bits);
    endtask

    task automatic compare_all(string tag);
        check(tag, {24'd0, rx_data}, {24'd0, m_data});
        check(tag, {31'd0, rx_bit9}, {31'd0, m_bit9});
        check(tag, {31'd0, rx_flag}, {31'd0, m_flag});
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
        m_flag = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4021));
        repeat (5) @(negedge clk);
        // R1: reset values
        compare_all("R1 reset");
        rst_n = 1'b1;
        hold_bits(1);
        compare_all("R1 after release");

        // R5 R3: plain commit, filter off
        frame_and_model(8'hA5, 1'b0, 1'b1, 2);
        compare_all("R5 R3 commit A5");

        // R7: flag still set, frame dropped
        frame_and_model(8'h3C, 1'b1, 1'b1, 2);
        compare_all("R7 drop when full");

        // R8: flag clears, data kept
        clear_flag();
        compare_all("R8 clear keeps data");

        // R6: filter on, ninth bit 0 dropped
        addr_filter_en = 1'b1;
        frame_and_model(8'h5A, 1'b0, 1'b1, 2);
        compare_all("R6 filtered out");

        // R5: filter on, ninth bit 1 committed
        frame_and_model(8'h81, 1'b1, 1'b1, 2);
        compare_all("R5 address frame");
        addr_filter_en = 1'b0;
        clear_flag();

        // R9: low stop bit does not matter
        frame_and_model(8'h0F, 1'b1, 1'b0, 2);
        compare_all("R9 low stop bit");
        clear_flag();

        // R2: disabled receiver ignores a frame
        rx_enable = 1'b0;
        frame_and_model(8'hEE, 1'b1, 1'b1, 2);
        compare_all("R2 disabled");
        rx_enable = 1'b1;

        // R4: short low glitch, then a real frame
        rx_pin = 1'b0;
        for (int i = 0; i < 3 * TICK_DIV; i++) @(negedge clk);
        rx_pin = 1'b1;
        hold_bits(2);
        compare_all("R4 glitch ignored");
        frame_and_model(8'h96, 1'b0, 1'b1, 2);
        compare_all("R4 frame after glitch");
        clear_flag();

        // R10: dropped frame, then a back-to-back accepted frame
        addr_filter_en = 1'b1;
        frame_and_model(8'h11, 1'b0, 1'b1, 0);
        frame_and_model(8'h7E, 1'b1, 1'b1, 2);
        compare_all("R10 back to back");
        addr_filter_en = 1'b0;

        // random mix, R3 R5 R6 R7 R8
        for (int n = 0; n < 40; n++) begin
            if (($urandom % 10) < 7) clear_flag();
            addr_filter_en = 1'($urandom % 2);
            frame_and_model(8'($urandom), 1'($urandom % 2), 1'($urandom % 2),
                            1 + int'($urandom % 3));
            compare_all("R3 R5 random frame");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule